// File: doc/BRIEF.md
# Cluster Invalidation Fan-out Combiner

This block is the coherence agent of a mid-level cache shared by a small group of cores. It keeps, for every block held by the cluster cache, a presence flag, a write-permission flag and one bit per core that says which core caches hold a copy. Core caches report every eviction, so the bits are exact. Local reads and writes are resolved inside the cluster when the cluster holds enough permission. Otherwise they are passed to the last-level cache as an upward request, and the upper level later answers with a fill.

The upper level tracks whole clusters, not single cores. When it invalidates or recalls a block, this block sends one local invalidation to exactly the cores whose bits are set. It records them in a pending mask and clears one bit for each acknowledgment that arrives. When the mask reaches zero it sends one combined acknowledgment upward. Only one fan-out is in progress at a time. While it runs, traffic that touches that block waits.

Top module: `clu_inv_combiner`

## Requirements
- R1: After reset every block is absent with no sharers and no write permission. All ready outputs are high, no valid output is asserted, and a read to any block is forwarded upward.
- R2: A read (lreq_op 0) to a block present in the cluster completes locally. It gives lrsp_valid with lrsp_local=1 one cycle after acceptance, sets the reader's tracking bit and raises no upward request.
- R3: A read to an absent block, or a write (lreq_op 1) without cluster write permission, is forwarded upward. The cycle after acceptance shows up_req_valid with the requester's core number, up_req_wr equal to 1 for a write, and lrsp_valid with lrsp_local=0.
- R4: A read fill marks the block present and adds the core to the sharers. A write fill grants write permission and leaves the core as the only sharer. Any other local sharers get a local invalidation one cycle later, and their acknowledgments produce no upward acknowledgment.
- R5: An accepted upstream invalidation produces linv_valid one cycle later. linv_mask equals exactly the tracking bits the block had (bit i is core i), and linv_blk carries the block.
- R6: Exactly one up_ack_valid pulse is sent per upstream invalidation. It comes in the cycle after the acknowledgment that clears the last pending bit, and not before. Acknowledgments from cores that are not pending are ignored.
- R7: An upstream invalidation of a block with no local sharers gives up_ack_valid one cycle later, with no local invalidation.
- R8: An eviction (lreq_op 2) clears the evicting core's tracking bit, so a later invalidation of that block does not include that core.
- R9: While a fan-out is in progress, up_inv_ready and up_fill_ready are low. lreq_ready is low for writes and for any request to the block in progress. Reads to other blocks are still accepted.
- R10: After an upstream invalidation the block is absent, so the next read to it is forwarded upward.
- R11: When several sources are valid in one cycle, an upstream invalidation wins over a fill, and a fill wins over a local request. The losers see their ready low.
- R12: A write by a core to a block where the cluster holds write permission completes locally (lrsp_local=1). It makes that core the only sharer and sends a local invalidation to the previous sharers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lreq_valid | input | 1 | Local request valid |
| lreq_ready | output | 1 | Local request accepted this cycle |
| lreq_op | input | 2 | 0 read, 1 write, 2 eviction |
| lreq_core | input | CW | Requesting core |
| lreq_blk | input | AW | Block index |
| lrsp_valid | output | 1 | Read or write decision valid |
| lrsp_core | output | CW | Core the decision is for |
| lrsp_local | output | 1 | 1 completed in cluster, 0 forwarded upward |
| up_req_valid | output | 1 | Upward request valid |
| up_req_wr | output | 1 | Upward request needs write permission |
| up_req_core | output | CW | Core that missed |
| up_req_blk | output | AW | Block index |
| up_fill_valid | input | 1 | Fill from upper level valid |
| up_fill_ready | output | 1 | Fill accepted this cycle |
| up_fill_wr | input | 1 | Fill grants write permission |
| up_fill_core | input | CW | Core the fill is for |
| up_fill_blk | input | AW | Block index |
| up_inv_valid | input | 1 | Upstream invalidation or recall valid |
| up_inv_ready | output | 1 | Upstream invalidation accepted this cycle |
| up_inv_blk | input | AW | Block index |
| up_ack_valid | output | 1 | Combined acknowledgment pulse |
| up_ack_blk | output | AW | Block acknowledged |
| linv_valid | output | 1 | Local invalidation pulse |
| linv_mask | output | NCORE | Cores to invalidate |
| linv_blk | output | AW | Block index |
| lack | input | NCORE | Per-core invalidation acknowledgments |

## Verification
Every one of the sixteen sharer sets over four cores is built up through reads and fills, then invalidated from above. Each check confirms that the fan-out mask equals the set, so it catches a wrong or missing tracking bit. Acknowledgments are returned one core at a time, in ascending order for some sets and descending order for others, with repeated acknowledgments mixed in, or all in one cycle. These cases separate an early or doubled combined reply from a correct one. The empty set shows the immediate reply. Separate sequences cover write fills, local writes that hold permission, evictions and a three-way arbitration collision, each of which changes a different part of the tracking state.

// File: rtl/clu_inv_pkg.sv
package clu_inv_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EVICT = 2'd2,
        OP_NONE  = 2'd3
    } lop_e;

    // Which side asked for a local fan-out.
    typedef enum logic {
        SRC_LOCAL    = 1'b0,
        SRC_UPSTREAM = 1'b1
    } fan_src_e;

    localparam int DEF_NCORE = 4;
    localparam int DEF_NBLK  = 8;

endpackage

// File: rtl/clu_track.sv
module clu_track #(
    parameter int NCORE = 4,
    parameter int NBLK  = 8,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    rd_blk,
    output logic             rd_present,
    output logic             rd_wperm,
    output logic [NCORE-1:0] rd_share,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_blk,
    input  logic             wr_present,
    input  logic             wr_wperm,
    input  logic [NCORE-1:0] wr_share
);

    logic [NBLK-1:0]  present_q;
    logic [NBLK-1:0]  wperm_q;
    logic [NCORE-1:0] share_q [NBLK];

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '0;
            wperm_q   <= '0;
            for (int b = 0; b < NBLK; b++) share_q[b] <= '0;
        end else if (wr_en) begin
            present_q[wr_blk] <= wr_present;
            wperm_q[wr_blk]   <= wr_wperm;
            share_q[wr_blk]   <= wr_share;
        end
    end

    assign rd_present = present_q[rd_blk];
    assign rd_wperm   = wperm_q[rd_blk];
    assign rd_share   = share_q[rd_blk];

    // R2
    incl_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_share != '0) |-> rd_present);

    // R12
    wperm_pres_chk: assert property (@(posedge clk) disable iff (rst)
        rd_wperm |-> rd_present);

endmodule

// File: rtl/clu_fanout.sv
module clu_fanout
    import clu_inv_pkg::*;
#(
    parameter int NCORE = 4,
    parameter int NBLK  = 8,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NCORE-1:0] start_mask,
    input  logic [AW-1:0]    start_blk,
    input  fan_src_e         start_src,
    input  logic [NCORE-1:0] lack,
    output logic             busy,
    output logic [AW-1:0]    cur_blk,
    output logic             linv_valid,
    output logic [NCORE-1:0] linv_mask,
    output logic [AW-1:0]    linv_blk,
    output logic             ack_valid,
    output logic [AW-1:0]    ack_blk
);

    logic [NCORE-1:0] pend_q;
    logic [NCORE-1:0] pend_nxt;
    fan_src_e         src_q;

    assign pend_nxt = pend_q & ~lack;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            cur_blk    <= '0;
            pend_q     <= '0;
            src_q      <= SRC_LOCAL;
            linv_valid <= 1'b0;
            linv_mask  <= '0;
            linv_blk   <= '0;
            ack_valid  <= 1'b0;
            ack_blk    <= '0;
        end else begin
            linv_valid <= 1'b0;
            ack_valid  <= 1'b0;
            if (!busy) begin
                if (start) begin
                    cur_blk <= start_blk;
                    src_q   <= start_src;
                    if (start_mask == '0) begin
                        ack_valid <= (start_src == SRC_UPSTREAM);
                        ack_blk   <= start_blk;
                    end else begin
                        busy       <= 1'b1;
                        pend_q     <= start_mask;
                        linv_valid <= 1'b1;
                        linv_mask  <= start_mask;
                        linv_blk   <= start_blk;
                    end
                end
            end else begin
                pend_q <= pend_nxt;
                if (pend_nxt == '0) begin
                    busy      <= 1'b0;
                    ack_valid <= (src_q == SRC_UPSTREAM);
                    ack_blk   <= cur_blk;
                end
            end
        end
    end

    // R6
    pend_shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ((pend_q & ~$past(pend_q)) == '0));

    // R7
    linv_nz_chk: assert property (@(posedge clk) disable iff (rst)
        linv_valid |-> (linv_mask != '0));

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);

    // R6
    ack_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> !busy);

endmodule

// File: rtl/clu_inv_combiner.sv
module clu_inv_combiner
    import clu_inv_pkg::*;
#(
    parameter int NCORE = DEF_NCORE,
    parameter int NBLK  = DEF_NBLK,
    localparam int AW   = (NBLK > 1) ? $clog2(NBLK) : 1,
    localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lreq_valid,
    output logic             lreq_ready,
    input  logic [1:0]       lreq_op,
    input  logic [CW-1:0]    lreq_core,
    input  logic [AW-1:0]    lreq_blk,
    output logic             lrsp_valid,
    output logic [CW-1:0]    lrsp_core,
    output logic             lrsp_local,
    output logic             up_req_valid,
    output logic             up_req_wr,
    output logic [CW-1:0]    up_req_core,
    output logic [AW-1:0]    up_req_blk,
    input  logic             up_fill_valid,
    output logic             up_fill_ready,
    input  logic             up_fill_wr,
    input  logic [CW-1:0]    up_fill_core,
    input  logic [AW-1:0]    up_fill_blk,
    input  logic             up_inv_valid,
    output logic             up_inv_ready,
    input  logic [AW-1:0]    up_inv_blk,
    output logic             up_ack_valid,
    output logic [AW-1:0]    up_ack_blk,
    output logic             linv_valid,
    output logic [NCORE-1:0] linv_mask,
    output logic [AW-1:0]    linv_blk,
    input  logic [NCORE-1:0] lack
);

    lop_e             op;
    logic             busy;
    logic [AW-1:0]    cur_blk;
    logic             take_inv, take_fill, take_req;
    logic [AW-1:0]    rd_blk;
    logic             t_pres, t_wp;
    logic [NCORE-1:0] t_sh;
    logic             wr_en, wr_present, wr_wperm;
    logic [NCORE-1:0] wr_share;
    logic             st;
    logic [NCORE-1:0] st_mask;
    fan_src_e         st_src;
    logic [NCORE-1:0] rbit, fbit;
    logic             rsp_v, rsp_loc, fwd_v, fwd_wr;

    assign op = lop_e'(lreq_op);

    // Fixed priority: upstream invalidation, then fill, then local request.
    assign up_inv_ready  = !busy;
    assign up_fill_ready = !busy && !up_inv_valid;
    assign lreq_ready    = !(up_inv_valid && !busy) && !(up_fill_valid && !busy)
                           && !(busy && (op == OP_WRITE || lreq_blk == cur_blk));

    assign take_inv  = up_inv_valid && up_inv_ready;
    assign take_fill = up_fill_valid && up_fill_ready;
    assign take_req  = lreq_valid && lreq_ready;

    assign rd_blk = take_inv ? up_inv_blk : (take_fill ? up_fill_blk : lreq_blk);

    always_comb begin
        rbit = '0;
        rbit[lreq_core] = 1'b1;
        fbit = '0;
        fbit[up_fill_core] = 1'b1;
    end

    always_comb begin
        wr_en      = 1'b0;
        wr_present = t_pres;
        wr_wperm   = t_wp;
        wr_share   = t_sh;
        st         = 1'b0;
        st_mask    = '0;
        st_src     = SRC_LOCAL;
        rsp_v      = 1'b0;
        rsp_loc    = 1'b0;
        fwd_v      = 1'b0;
        fwd_wr     = 1'b0;
        if (take_inv) begin
            wr_en      = 1'b1;
            wr_present = 1'b0;
            wr_wperm   = 1'b0;
            wr_share   = '0;
            st         = 1'b1;
            st_mask    = t_sh;
            st_src     = SRC_UPSTREAM;
        end else if (take_fill) begin
            wr_en      = 1'b1;
            wr_present = 1'b1;
            if (up_fill_wr) begin
                wr_wperm = 1'b1;
                wr_share = fbit;
                st_mask  = t_sh & ~fbit;
                st       = (st_mask != '0);
            end else begin
                wr_wperm = 1'b0;
                wr_share = t_sh | fbit;
            end
        end else if (take_req) begin
            unique case (op)
                OP_READ: begin
                    rsp_v = 1'b1;
                    if (t_pres) begin
                        wr_en    = 1'b1;
                        wr_share = t_sh | rbit;
                        rsp_loc  = 1'b1;
                    end else begin
                        fwd_v = 1'b1;
                    end
                end
                OP_WRITE: begin
                    rsp_v = 1'b1;
                    if (t_pres && t_wp) begin
                        wr_en    = 1'b1;
                        wr_share = rbit;
                        st_mask  = t_sh & ~rbit;
                        st       = (st_mask != '0);
                        rsp_loc  = 1'b1;
                    end else begin
                        fwd_v  = 1'b1;
                        fwd_wr = 1'b1;
                    end
                end
                OP_EVICT: begin
                    wr_en    = 1'b1;
                    wr_share = t_sh & ~rbit;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lrsp_valid   <= 1'b0;
            lrsp_core    <= '0;
            lrsp_local   <= 1'b0;
            up_req_valid <= 1'b0;
            up_req_wr    <= 1'b0;
            up_req_core  <= '0;
            up_req_blk   <= '0;
        end else begin
            lrsp_valid   <= rsp_v;
            lrsp_core    <= lreq_core;
            lrsp_local   <= rsp_loc;
            up_req_valid <= fwd_v;
            up_req_wr    <= fwd_wr;
            up_req_core  <= lreq_core;
            up_req_blk   <= lreq_blk;
        end
    end

    clu_track #(.NCORE(NCORE), .NBLK(NBLK)) u_track (
        .clk        (clk),
        .rst        (rst),
        .rd_blk     (rd_blk),
        .rd_present (t_pres),
        .rd_wperm   (t_wp),
        .rd_share   (t_sh),
        .wr_en      (wr_en),
        .wr_blk     (rd_blk),
        .wr_present (wr_present),
        .wr_wperm   (wr_wperm),
        .wr_share   (wr_share)
    );

    clu_fanout #(.NCORE(NCORE), .NBLK(NBLK)) u_fanout (
        .clk        (clk),
        .rst        (rst),
        .start      (st),
        .start_mask (st_mask),
        .start_blk  (rd_blk),
        .start_src  (st_src),
        .lack       (lack),
        .busy       (busy),
        .cur_blk    (cur_blk),
        .linv_valid (linv_valid),
        .linv_mask  (linv_mask),
        .linv_blk   (linv_blk),
        .ack_valid  (up_ack_valid),
        .ack_blk    (up_ack_blk)
    );

    // R3
    fwd_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (lrsp_valid && !lrsp_local) |-> up_req_valid);

    // R5
    inv_fan_chk: assert property (@(posedge clk) disable iff (rst)
        (up_inv_valid && up_inv_ready) |=> (linv_valid || up_ack_valid));

endmodule

// File: tb/clu_inv_combiner_bench.sv
module clu_inv_combiner_bench;

    localparam int NCORE = 4;
    localparam int NBLK  = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       lreq_valid = 1'b0;
    logic       lreq_ready;
    logic [1:0] lreq_op = 2'd0;
    logic [1:0] lreq_core = '0;
    logic [2:0] lreq_blk = '0;
    logic       lrsp_valid;
    logic [1:0] lrsp_core;
    logic       lrsp_local;
    logic       up_req_valid, up_req_wr;
    logic [1:0] up_req_core;
    logic [2:0] up_req_blk;
    logic       up_fill_valid = 1'b0;
    logic       up_fill_ready;
    logic       up_fill_wr = 1'b0;
    logic [1:0] up_fill_core = '0;
    logic [2:0] up_fill_blk = '0;
    logic       up_inv_valid = 1'b0;
    logic       up_inv_ready;
    logic [2:0] up_inv_blk = '0;
    logic       up_ack_valid;
    logic [2:0] up_ack_blk;
    logic       linv_valid;
    logic [3:0] linv_mask;
    logic [2:0] linv_blk;
    logic [3:0] lack = '0;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    clu_inv_combiner #(.NCORE(NCORE), .NBLK(NBLK)) u_clu_inv_combiner (
        .clk(clk), .rst(rst),
        .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_op(lreq_op),
        .lreq_core(lreq_core), .lreq_blk(lreq_blk),
        .lrsp_valid(lrsp_valid), .lrsp_core(lrsp_core), .lrsp_local(lrsp_local),
        .up_req_valid(up_req_valid), .up_req_wr(up_req_wr),
        .up_req_core(up_req_core), .up_req_blk(up_req_blk),
        .up_fill_valid(up_fill_valid), .up_fill_ready(up_fill_ready),
        .up_fill_wr(up_fill_wr), .up_fill_core(up_fill_core), .up_fill_blk(up_fill_blk),
        .up_inv_valid(up_inv_valid), .up_inv_ready(up_inv_ready), .up_inv_blk(up_inv_blk),
        .up_ack_valid(up_ack_valid), .up_ack_blk(up_ack_blk),
        .linv_valid(linv_valid), .linv_mask(linv_mask), .linv_blk(linv_blk),
        .lack(lack)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic req(input int op, input int core, input int blk);
        lreq_op = 2'(op); lreq_core = 2'(core); lreq_blk = 3'(blk);
        lreq_valid = 1'b1;
        tick();
        lreq_valid = 1'b0;
    endtask

    task automatic fill(input bit wr, input int core, input int blk);
        up_fill_wr = wr; up_fill_core = 2'(core); up_fill_blk = 3'(blk);
        up_fill_valid = 1'b1;
        tick();
        up_fill_valid = 1'b0;
    endtask

    task automatic inv(input int blk);
        up_inv_blk = 3'(blk);
        up_inv_valid = 1'b1;
        tick();
        up_inv_valid = 1'b0;
    endtask

    task automatic ackm(input int m);
        lack = 4'(m);
        tick();
        lack = '0;
    endtask

    task automatic done();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        done();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #4;
        // R1 reset state
        chk("R1 lrsp_valid", lrsp_valid, 0);
        chk("R1 up_ack_valid", up_ack_valid, 0);
        chk("R1 linv_valid", linv_valid, 0);
        chk("R1 up_inv_ready", up_inv_ready, 1);
        chk("R1 up_fill_ready", up_fill_ready, 1);
        chk("R1 lreq_ready", lreq_ready, 1);
        req(0, 1, 3);
        chk("R1 read fwd", up_req_valid, 1);
        chk("R1 read nonlocal", lrsp_local, 0);

        // R7 empty sharer set
        inv(0);
        chk("R7 ack immediate", up_ack_valid, 1);
        chk("R7 ack blk", up_ack_blk, 0);
        chk("R7 no linv", linv_valid, 0);
        tick();
        chk("R7 single ack", up_ack_valid, 0);

        // Sweep every nonempty sharer set
        for (int p = 1; p < 16; p++) begin
            int blk;
            int first;
            int acked;
            int left;
            blk = p % 8;
            first = 0;
            for (int c = 3; c >= 0; c--) if (p[c]) first = c;
            req(0, first, blk);
            chk("R3 fwd valid", up_req_valid, 1);
            chk("R3 fwd core", up_req_core, first);
            chk("R3 fwd wr", up_req_wr, 0);
            chk("R3 rsp nonlocal", lrsp_local, 0);
            fill(1'b0, first, blk);
            chk("R4 read fill no linv", linv_valid, 0);
            for (int c = 0; c < 4; c++) begin
                if (p[c] && c != first) begin
                    req(0, c, blk);
                    chk("R2 local rsp", lrsp_valid && lrsp_local, 1);
                    chk("R2 no upward", up_req_valid, 0);
                end
            end
            inv(blk);
            chk("R5 linv valid", linv_valid, 1);
            chk("R5 linv mask", linv_mask, p);
            chk("R5 linv blk", linv_blk, blk);
            chk("R6 no early ack", up_ack_valid, 0);
            // R9 stall rules while the fan-out runs
            lreq_op = 2'd0; lreq_blk = 3'((blk + 1) % 8);
            #1 chk("R9 other read ready", lreq_ready, 1);
            lreq_blk = 3'(blk);
            #1 chk("R9 same blk stalled", lreq_ready, 0);
            lreq_op = 2'd1; lreq_blk = 3'((blk + 1) % 8);
            #1 chk("R9 write stalled", lreq_ready, 0);
            chk("R9 inv stalled", up_inv_ready, 0);
            chk("R9 fill stalled", up_fill_ready, 0);
            if (p == 15) begin
                ackm(15);
                chk("R6 ack all at once", up_ack_valid, 1);
            end else begin
                acked = 0;
                left = p;
                for (int k = 0; k < 4; k++) begin
                    int c;
                    c = (p % 2 == 0) ? k : 3 - k;
                    if (p[c]) begin
                        left = left & ~(1 << c);
                        ackm((1 << c) | acked);
                        acked = acked | (1 << c);
                        chk("R6 ack only at end", up_ack_valid, (left == 0) ? 1 : 0);
                    end
                end
            end
            chk("R6 ack blk", up_ack_blk, blk);
            tick();
            chk("R6 exactly one ack", up_ack_valid, 0);
            chk("R6 engine free", up_inv_ready, 1);
            req(0, 0, blk);
            chk("R10 absent after inv", lrsp_local, 0);
            chk("R10 forwarded", up_req_valid, 1);
        end

        // R4 write fill with other local sharers
        req(0, 0, 5); fill(1'b0, 0, 5); req(0, 1, 5); req(0, 2, 5);
        req(1, 1, 5);
        chk("R3 write fwd", up_req_valid && up_req_wr, 1);
        chk("R3 write core", up_req_core, 1);
        fill(1'b1, 1, 5);
        chk("R4 sibling linv", linv_valid, 1);
        chk("R4 sibling mask", linv_mask, 5);
        ackm(5);
        chk("R4 no upward ack", up_ack_valid, 0);
        chk("R4 engine free", up_inv_ready, 1);
        // R12 write with cluster write permission
        req(1, 3, 5);
        chk("R12 local write", lrsp_valid && lrsp_local, 1);
        chk("R12 no upward", up_req_valid, 0);
        chk("R12 previous sharer linv", linv_mask, 2);
        ackm(2);
        chk("R12 no upward ack", up_ack_valid, 0);
        inv(5);
        chk("R12 sole sharer", linv_mask, 8);
        ackm(8);
        chk("R12 combined ack", up_ack_valid, 1);

        // R8 eviction clears the bit
        req(0, 0, 6); fill(1'b0, 0, 6); req(0, 3, 6); req(2, 0, 6);
        chk("R8 evict no rsp", lrsp_valid, 0);
        inv(6);
        chk("R8 mask after evict", linv_mask, 8);
        ackm(8);
        chk("R8 ack", up_ack_valid, 1);

        // R11 three-way collision
        req(0, 2, 7); fill(1'b0, 2, 7);
        up_inv_blk = 3'd7; up_inv_valid = 1'b1;
        up_fill_blk = 3'd2; up_fill_core = 2'd1; up_fill_wr = 1'b0; up_fill_valid = 1'b1;
        lreq_op = 2'd0; lreq_core = 2'd1; lreq_blk = 3'd7; lreq_valid = 1'b1;
        #1;
        chk("R11 inv wins", up_inv_ready, 1);
        chk("R11 fill loses", up_fill_ready, 0);
        chk("R11 req loses", lreq_ready, 0);
        tick();
        up_inv_valid = 1'b0; up_fill_valid = 1'b0; lreq_valid = 1'b0;
        chk("R11 inv taken", linv_mask, 4);
        chk("R11 req not taken", lrsp_valid, 0);
        ackm(4);
        chk("R11 ack", up_ack_valid, 1);

        tick();
        done();
    end

endmodule